// File: doc/BRIEF.md
# CCD Clock Waveform Sequencer

This block plays back CCD readout waveforms from tables that a host loads beforehand. Short waveform pieces, called clocking units, live in a step memory. Each step is a 64-bit output vector with a dwell time in system clock cycles. Typical clocking units are a parallel image shift, a serial register shift or a pixel sample. A sequence table lists which unit to play and how many times to play it. The sequencer walks this table entry by entry to build a full readout.

The low 32 bits of every vector drive CCD clock lines. The high 32 bits drive internal controls, for example the strobe that starts an ADC conversion. All 64 lines come from one register, so they change together on one clock edge. Consecutive steps, repeats and table entries follow each other with no idle cycle between them.

The host loads the tables through one write port with a region select. A start pulse launches playback. A stop pulse aborts playback at the next step boundary. Busy marks a run in progress, and a one-cycle done pulse marks a normal end.

Top module: `ccd_wave_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, clk_out and ctl_out are zero and busy and done are low. The stored idle vector is also zero.
- R2: wr_sel selects the region that a write goes to, with wr_addr as the entry index:
  - 0 selects a step. wr_data[63:0] is the vector and wr_data[79:64] is the dwell.
  - 1 selects a unit, addressed by wr_addr[3:0]. wr_data[7:0] is the first step address and wr_data[15:8] is the step count.
  - 2 selects a sequence entry, addressed by wr_addr[4:0]. wr_data[15:0] is the repeat count, wr_data[19:16] is the unit index and wr_data[20] is the end flag.
  - 3 sets the idle vector from wr_data[63:0].
- R3: Vector bits [31:0] appear on clk_out and bits [63:32] appear on ctl_out, both updated on the same edge.
- R4: Each played step holds its vector for exactly dwell cycles. A dwell of 0 holds for 1 cycle.
- R5: A unit plays its steps in order from its first address. The step address wraps modulo 256. A step count of 0 plays one step.
- R6: A sequence entry plays its unit repeat-count times in a row. A repeat count of 0 plays the unit once.
- R7: Entries play in table order starting from entry 0, with no extra cycle between steps, repeats or entries.
- R8: When an entry with the end flag finishes, or when entry 31 finishes, one edge does three things: done is set high for exactly one cycle, busy drops, and the outputs show the idle vector.
- R9: A start sampled while idle makes the first step's vector appear on the next edge, with busy high. A start sampled while busy has no effect.
- R10: While idle, the outputs show the idle vector. A new idle value appears two edges after its write is sampled.
- R11: Writes sampled while busy is high change no memory and do not change the idle vector.
- R12: A stop sampled during a step ends playback when that step's dwell ends. The outputs then show the idle vector, busy drops and done stays low. A stop sampled while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Write region select |
| wr_addr | input | 8 | Entry index within the region |
| wr_data | input | 80 | Write payload |
| start | input | 1 | Begin playback from sequence entry 0 |
| stop | input | 1 | Abort playback at the next step boundary |
| busy | output | 1 | Playback in progress |
| done | output | 1 | One-cycle pulse on normal completion |
| clk_out | output | 32 | CCD clock lines |
| ctl_out | output | 32 | Internal control lines, such as the ADC strobe |

## Verification
The assertions watch several properties on every cycle:
- the vector stays frozen while a dwell is counting down;
- done lasts one cycle and only comes at the end of a run;
- busy rises only after a start;
- an abort never raises done;
- the idle vector cannot change while busy is high.

Only the directed scenarios can show the content of playback: the exact vector in each cycle, dwell and repeat counts of zero, address wrap inside a unit, and chaining of entries without gaps. They also show that a run without an end flag ends after entry 31, that a stop landing on the last cycle of a step aborts at once, and that a write made during a run leaves the playback unchanged.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;
    localparam int OUT_W     = 64;
    localparam int CLK_LINES = 32;
    localparam int CTL_LINES = OUT_W - CLK_LINES;
    localparam int DWELL_W   = 16;
    localparam int STEP_AW   = 8;
    localparam int UNIT_AW   = 4;
    localparam int SEQ_AW    = 5;
    localparam int REP_W     = 16;
    localparam int STEP_W    = OUT_W + DWELL_W;
    localparam int UNIT_EW   = 2 * STEP_AW;
    localparam int SEQ_EW    = REP_W + UNIT_AW + 1;

    typedef enum logic [1:0] {
        RGN_STEP = 2'd0,
        RGN_UNIT = 2'd1,
        RGN_SEQ  = 2'd2,
        RGN_IDLE = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        LD_NONE,
        LD_NEXT,
        LD_REPEAT,
        LD_ENTRY
    } load_e;

    typedef struct packed {
        logic                run;
        logic                done;
        logic                stop_pend;
        logic                last_entry;
        logic [SEQ_AW-1:0]   seq_ptr;
        logic [STEP_AW-1:0]  ustart;
        logic [STEP_AW-1:0]  ulen;
        logic [STEP_AW-1:0]  step_ptr;
        logic [STEP_AW-1:0]  step_left;
        logic [REP_W-1:0]    rep_left;
        logic [DWELL_W-1:0]  dwell;
        logic [OUT_W-1:0]    vec;
    } eng_t;
endpackage

// File: rtl/cseq_regfile.sv
module cseq_regfile #(
    parameter int AW = 8,
    parameter int DW = 80
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    // Asynchronous read lets the engine chain lookups inside one cycle.
    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cseq_engine.sv
module cseq_engine
    import ccdseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic [OUT_W-1:0]   idle_vec_i,
    output logic [SEQ_AW-1:0]  seq_raddr_o,
    input  logic [SEQ_EW-1:0]  seq_rdata_i,
    output logic [UNIT_AW-1:0] unit_raddr_o,
    input  logic [UNIT_EW-1:0] unit_rdata_i,
    output logic [STEP_AW-1:0] step_raddr_o,
    input  logic [STEP_W-1:0]  step_rdata_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [OUT_W-1:0]   vec_o
);
    eng_t  st_d, st_q;
    load_e ld;

    logic [REP_W-1:0]   ent_rep;
    logic [UNIT_AW-1:0] ent_unit;
    logic               ent_end;
    logic [STEP_AW-1:0] u_start;
    logic [STEP_AW-1:0] u_len;
    logic [STEP_AW-1:0] len_eff;
    logic [REP_W-1:0]   rep_eff;
    logic [DWELL_W-1:0] step_dwell;

    always_comb begin
        st_d = st_q;
        st_d.done = 1'b0;
        ld = LD_NONE;

        // Sequence lookup: entry 0 on start, else the following entry.
        seq_raddr_o  = st_q.run ? st_q.seq_ptr + 1'b1 : '0;
        ent_rep      = seq_rdata_i[REP_W-1:0];
        ent_unit     = seq_rdata_i[REP_W +: UNIT_AW];
        ent_end      = seq_rdata_i[SEQ_EW-1];
        unit_raddr_o = ent_unit;
        u_start      = unit_rdata_i[STEP_AW-1:0];
        u_len        = unit_rdata_i[UNIT_EW-1:STEP_AW];
        len_eff      = (u_len == '0) ? STEP_AW'(1) : u_len;
        rep_eff      = (ent_rep == '0) ? REP_W'(1) : ent_rep;

        if (!st_q.run) begin
            st_d.stop_pend = 1'b0;
            st_d.vec       = idle_vec_i;
            if (start_i) begin
                ld = LD_ENTRY;
            end
        end else if (st_q.dwell > DWELL_W'(1)) begin
            st_d.dwell = st_q.dwell - 1'b1;
            if (stop_i) begin
                st_d.stop_pend = 1'b1;
            end
        end else if (st_q.stop_pend || stop_i) begin
            st_d.run       = 1'b0;
            st_d.stop_pend = 1'b0;
            st_d.vec       = idle_vec_i;
        end else if (st_q.step_left > STEP_AW'(1)) begin
            ld = LD_NEXT;
        end else if (st_q.rep_left > REP_W'(1)) begin
            ld = LD_REPEAT;
        end else if (st_q.last_entry) begin
            st_d.run  = 1'b0;
            st_d.done = 1'b1;
            st_d.vec  = idle_vec_i;
        end else begin
            ld = LD_ENTRY;
        end

        case (ld)
            LD_NEXT:   step_raddr_o = st_q.step_ptr + 1'b1;
            LD_REPEAT: step_raddr_o = st_q.ustart;
            default:   step_raddr_o = u_start;
        endcase
        step_dwell = step_rdata_i[OUT_W +: DWELL_W];

        if (ld != LD_NONE) begin
            st_d.run      = 1'b1;
            st_d.vec      = step_rdata_i[OUT_W-1:0];
            st_d.dwell    = (step_dwell == '0) ? DWELL_W'(1) : step_dwell;
            st_d.step_ptr = step_raddr_o;
            case (ld)
                LD_NEXT: begin
                    st_d.step_left = st_q.step_left - 1'b1;
                end
                LD_REPEAT: begin
                    st_d.step_left = st_q.ulen;
                    st_d.rep_left  = st_q.rep_left - 1'b1;
                end
                default: begin
                    st_d.seq_ptr    = seq_raddr_o;
                    st_d.ustart     = u_start;
                    st_d.ulen       = len_eff;
                    st_d.step_left  = len_eff;
                    st_d.rep_left   = rep_eff;
                    st_d.last_entry = ent_end || (&seq_raddr_o);
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.run;
    assign done_o = st_q.done;
    assign vec_o  = st_q.vec;

    AST_DWELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.dwell > DWELL_W'(1)) |=> $stable(st_q.vec)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done); // R8
    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (!st_q.run && $past(st_q.run))); // R8
    AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.run) |-> $past(start_i)); // R9
    AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.stop_pend) |=> !st_q.done); // R12
endmodule

// File: rtl/ccd_wave_seq.sv
module ccd_wave_seq
    import ccdseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [STEP_AW-1:0]   wr_addr,
    input  logic [STEP_W-1:0]    wr_data,
    input  logic                 start,
    input  logic                 stop,
    output logic                 busy,
    output logic                 done,
    output logic [CLK_LINES-1:0] clk_out,
    output logic [CTL_LINES-1:0] ctl_out
);
    logic               wr_ok;
    logic [OUT_W-1:0]   idle_d, idle_q;
    logic [SEQ_AW-1:0]  seq_raddr;
    logic [SEQ_EW-1:0]  seq_rdata;
    logic [UNIT_AW-1:0] unit_raddr;
    logic [UNIT_EW-1:0] unit_rdata;
    logic [STEP_AW-1:0] step_raddr;
    logic [STEP_W-1:0]  step_rdata;
    logic [OUT_W-1:0]   vec;

    assign wr_ok = wr_en && !busy;

    always_comb begin
        idle_d = idle_q;
        if (wr_ok && wr_sel == RGN_IDLE) begin
            idle_d = wr_data[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else begin
            idle_q <= idle_d;
        end
    end

    cseq_regfile #(.AW(STEP_AW), .DW(STEP_W)) u_step_mem (
        .clk     (clk),
        .we_i    (wr_ok && wr_sel == RGN_STEP),
        .waddr_i (wr_addr),
        .wdata_i (wr_data),
        .raddr_i (step_raddr),
        .rdata_o (step_rdata)
    );

    cseq_regfile #(.AW(UNIT_AW), .DW(UNIT_EW)) u_unit_tab (
        .clk     (clk),
        .we_i    (wr_ok && wr_sel == RGN_UNIT),
        .waddr_i (wr_addr[UNIT_AW-1:0]),
        .wdata_i (wr_data[UNIT_EW-1:0]),
        .raddr_i (unit_raddr),
        .rdata_o (unit_rdata)
    );

    cseq_regfile #(.AW(SEQ_AW), .DW(SEQ_EW)) u_seq_tab (
        .clk     (clk),
        .we_i    (wr_ok && wr_sel == RGN_SEQ),
        .waddr_i (wr_addr[SEQ_AW-1:0]),
        .wdata_i (wr_data[SEQ_EW-1:0]),
        .raddr_i (seq_raddr),
        .rdata_o (seq_rdata)
    );

    cseq_engine u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .stop_i       (stop),
        .idle_vec_i   (idle_q),
        .seq_raddr_o  (seq_raddr),
        .seq_rdata_i  (seq_rdata),
        .unit_raddr_o (unit_raddr),
        .unit_rdata_i (unit_rdata),
        .step_raddr_o (step_raddr),
        .step_rdata_i (step_rdata),
        .busy_o       (busy),
        .done_o       (done),
        .vec_o        (vec)
    );

    assign clk_out = vec[CLK_LINES-1:0];
    assign ctl_out = vec[OUT_W-1:CLK_LINES];

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(idle_q)); // R11
    AST_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $past(!busy, 2) && $stable(idle_q))
            |-> ({ctl_out, clk_out} == idle_q)); // R10
endmodule

// File: tb/ccd_wave_seq_tb.sv
`timescale 1ns/1ps
module ccd_wave_seq_tb_top;
    import ccdseq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [7:0]  wr_addr = 8'd0;
    logic [79:0] wr_data = '0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        busy, done;
    logic [31:0] clk_out, ctl_out;

    always #2 clk = ~clk;

    ccd_wave_seq dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data), .start(start), .stop(stop),
        .busy(busy), .done(done), .clk_out(clk_out), .ctl_out(ctl_out)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [63:0] sh_vec [256];
    logic [15:0] sh_dw  [256];
    logic [7:0]  sh_us  [16];
    logic [7:0]  sh_ul  [16];
    logic [3:0]  sh_su  [32];
    logic [15:0] sh_sr  [32];
    bit          sh_se  [32];
    logic [63:0] sh_idle = '0;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] a, logic [79:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic w_step(logic [7:0] a, logic [63:0] v, logic [15:0] d);
        wr(RGN_STEP, a, {d, v});
        sh_vec[a] = v; sh_dw[a] = d;
    endtask

    task automatic w_unit(logic [3:0] u, logic [7:0] s, logic [7:0] n);
        wr(RGN_UNIT, {4'd0, u}, {64'd0, n, s});
        sh_us[u] = s; sh_ul[u] = n;
    endtask

    task automatic w_seq(logic [4:0] e, logic [3:0] u, logic [15:0] r, bit f);
        wr(RGN_SEQ, {3'd0, e}, {59'd0, f, u, r});
        sh_su[e] = u; sh_sr[e] = r; sh_se[e] = f;
    endtask

    task automatic w_idle(logic [63:0] v);
        wr(RGN_IDLE, 8'd0, {16'd0, v});
        sh_idle = v;
    endtask

    // Plays the loaded tables and compares every cycle with a walk of the shadow tables.
    task automatic play(string req, int stop_cyc, int inj_cyc, logic [7:0] inj_addr);
        int cyc = 0;
        bit stopped = 0;
        bit abort = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int e = 0; e < 32 && !abort; e++) begin
            int u   = int'(sh_su[e]);
            int rep = (sh_sr[e] == 0) ? 1 : int'(sh_sr[e]);
            int len = (sh_ul[u] == 0) ? 1 : int'(sh_ul[u]);
            for (int r = 0; r < rep && !abort; r++) begin
                for (int s = 0; s < len && !abort; s++) begin
                    logic [7:0] a = sh_us[u] + 8'(s);
                    int d = (sh_dw[a] == 0) ? 1 : int'(sh_dw[a]);
                    for (int k = 0; k < d; k++) begin
                        chk(req, "vector", {ctl_out, clk_out}, sh_vec[a]);
                        chk(req, "busy during run", {63'd0, busy}, 64'd1);
                        chk(req, "done during run", {63'd0, done}, 64'd0);
                        if (cyc == stop_cyc) begin
                            stop = 1'b1; stopped = 1;
                        end
                        if (cyc == inj_cyc) begin
                            wr_en = 1'b1; wr_sel = RGN_STEP; wr_addr = inj_addr;
                            wr_data = {16'd7, ~sh_vec[inj_addr]}; start = 1'b1;
                        end else if (inj_cyc >= 0 && cyc == inj_cyc + 1) begin
                            wr_en = 1'b1; wr_sel = RGN_IDLE; wr_addr = 8'd0;
                            wr_data = {16'd0, ~sh_idle};
                        end
                        @(negedge clk);
                        stop = 1'b0; wr_en = 1'b0; start = 1'b0;
                        cyc++;
                    end
                    if (stopped) abort = 1;
                end
            end
            if (sh_se[e]) break;
        end
        chk(req, "idle vector after run", {ctl_out, clk_out}, sh_idle);
        chk(req, "busy after run", {63'd0, busy}, 64'd0);
        chk(req, "done at end", {63'd0, done}, {63'd0, !abort});
        @(negedge clk);
        chk(req, "done cleared", {63'd0, done}, 64'd0);
    endtask

    task automatic t_reset();
        chk("R1", "clk_out", {32'd0, clk_out}, 64'd0);
        chk("R1", "ctl_out", {32'd0, ctl_out}, 64'd0);
        chk("R1", "busy", {63'd0, busy}, 64'd0);
        chk("R1", "done", {63'd0, done}, 64'd0);
    endtask

    task automatic t_idle();
        w_idle(64'h0000_0100_0000_0055);
        @(negedge clk);
        chk("R10 R2", "idle vector", {ctl_out, clk_out}, 64'h0000_0100_0000_0055);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        @(negedge clk);
        chk("R12", "stop while idle", {ctl_out, clk_out}, sh_idle);
        chk("R12", "busy after idle stop", {63'd0, busy}, 64'd0);
    endtask

    task automatic t_single();
        w_step(8'd10, 64'h0000_0001_A5A5_0001, 16'd2);
        w_step(8'd11, 64'h0000_0000_5A5A_0002, 16'd0);
        w_step(8'd12, 64'h8000_0000_0000_0004, 16'd5);
        w_unit(4'd0, 8'd10, 8'd3);
        w_seq(5'd0, 4'd0, 16'd1, 1'b1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R3", "clk_out half", {32'd0, clk_out}, 64'h0000_0000_A5A5_0001);
        chk("R3", "ctl_out ADC strobe half", {32'd0, ctl_out}, 64'h0000_0000_0000_0001);
        chk("R9", "busy after start", {63'd0, busy}, 64'd1);
        repeat (10) @(negedge clk);
        play("R4 R5 R8 R9", -1, -1, 8'd0);
    endtask

    task automatic t_repeat();
        w_step(8'd254, 64'h1111_0000_0000_1111, 16'd1);
        w_step(8'd255, 64'h2222_0000_0000_2222, 16'd3);
        w_step(8'd0,   64'h3333_0000_0000_3333, 16'd2);
        w_unit(4'd1, 8'd254, 8'd3);
        w_unit(4'd2, 8'd12, 8'd0);
        w_seq(5'd0, 4'd1, 16'd3, 1'b0);
        w_seq(5'd1, 4'd2, 16'd0, 1'b0);
        w_seq(5'd2, 4'd0, 16'd2, 1'b1);
        play("R5 R6 R7", -1, -1, 8'd0);
    endtask

    task automatic t_chain();
        w_seq(5'd0, 4'd2, 16'd2, 1'b0);
        w_seq(5'd1, 4'd0, 16'd1, 1'b0);
        w_seq(5'd2, 4'd2, 16'd1, 1'b0);
        w_seq(5'd3, 4'd1, 16'd1, 1'b1);
        play("R7 R8", -1, -1, 8'd0);
    endtask

    task automatic t_noflag();
        w_step(8'd100, 64'hCAFE_0000_0000_00AA, 16'd1);
        w_step(8'd101, 64'h0000_BEEF_0000_00BB, 16'd1);
        w_unit(4'd3, 8'd100, 8'd1);
        w_unit(4'd4, 8'd101, 8'd1);
        for (int e = 0; e < 32; e++) begin
            w_seq(5'(e), (e % 2 == 0) ? 4'd3 : 4'd4, 16'd1, 1'b0);
        end
        play("R8 R7", -1, -1, 8'd0);
    endtask

    task automatic t_busy_writes();
        w_seq(5'd0, 4'd0, 16'd2, 1'b1);
        play("R11 R9", 1, 1, 8'd12);
        @(negedge clk);
        chk("R11", "idle vector kept", {ctl_out, clk_out}, sh_idle);
        play("R11", -1, -1, 8'd0);
    endtask

    task automatic t_stop();
        w_step(8'd20, 64'h0F0F_0F0F_0000_0001, 16'd6);
        w_step(8'd21, 64'hF0F0_F0F0_0000_0002, 16'd3);
        w_unit(4'd5, 8'd20, 8'd2);
        w_seq(5'd0, 4'd5, 16'd4, 1'b1);
        play("R12", 2, -1, 8'd0);
        play("R12", 8, -1, 8'd0);
        play("R12", -1, -1, 8'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_single();
        t_repeat();
        t_chain();
        t_noflag();
        t_busy_writes();
        t_stop();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule